// File: doc/BRIEF.md
# Branch Target Address Unit

This block sits in the branch stage of a 32-bit RISC core. Each cycle it takes the current instruction word, the address of that instruction and an externally evaluated taken/not-taken condition. It produces the address of the next instruction to fetch and a redirect flag that is raised only when a branch is actually taken. Instruction bits are numbered big-endian, so bit 0 is the most significant bit.

The unit owns the return-address register (LR) and the count register (CTR). Both registers can also be loaded through dedicated write ports, as a move-to-register instruction would do. A linking branch stores the address of the following instruction into LR. An indirect jump through CTR that does not link leaves LR untouched. This lets a small forwarding stub pass a call on while the original caller's return address is kept.

The instruction encoding used by this unit is as follows. The primary opcode is in bits 0–5. Opcode 18 is the unconditional displacement branch, with its displacement in bits 6–29. Opcode 16 is the conditional displacement branch, with its displacement in bits 16–29. Opcode 19 is the register-indirect group, and its extended opcode in bits 21–30 selects the target: value 16 jumps through LR and value 528 jumps through CTR. Bit 30 (absolute) and bit 31 (link) complete the word.

Top module: `branch_target_unit`

## Requirements
- R1: While rst_ni is low, LR and CTR are cleared to zero. After reset, a taken jump through LR, and a taken jump through CTR, each resolves to address 0.
- R2: For opcode 18 with bit 30 = 0, the target is the current address plus the 24-bit field from bits 6–29, shifted left by two and sign-extended. The branch is always taken, whatever the value of cond_taken_i.
- R3: For opcode 16 with bit 30 = 0 and cond_taken_i = 1, the target is the current address plus the 14-bit field from bits 16–29, shifted left by two and sign-extended.
- R4: When bit 30 = 1 on opcode 18 or opcode 16, the shifted and sign-extended displacement is used directly as the target address.
- R5: When a valid branch has bit 31 = 1, LR holds pc_i + 4 after the next rising clock edge. This applies whether or not the branch is taken.
- R6: When a conditional branch (opcode 16, or opcode 19 with extended opcode 16 or 528) has cond_taken_i = 0, next_pc_o equals pc_i + 4 and redirect_o is 0.
- R7: A taken jump through LR goes to LR with its two low bits cleared. If the same instruction also links, the target is computed from the LR value held before the update.
- R8: A taken jump through CTR goes to CTR with its two low bits cleared. When bit 31 = 0, LR keeps its value.
- R9: The external LR and CTR writes take effect only at the rising clock edge. If an LR write coincides with a linking branch, the branch's value is the one stored.
- R10: When valid_i is 0, or the word is not one of the branch encodings above, next_pc_o is pc_i + 4, redirect_o is 0 and LR does not change.
- R11: Every taken target has its two least significant bits forced to zero, even when pc_i or a register value is not word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction is present this cycle |
| instr_i | input | 32 | Instruction word, big-endian bit numbering |
| pc_i | input | 32 | Address of the current instruction |
| cond_taken_i | input | 1 | External condition result for conditional forms |
| lr_we_i | input | 1 | External LR write enable |
| lr_wdata_i | input | 32 | External LR write data |
| ctr_we_i | input | 1 | External CTR write enable |
| ctr_wdata_i | input | 32 | External CTR write data |
| next_pc_o | output | 32 | Address of the next instruction |
| redirect_o | output | 1 | High when a branch is taken |
| lr_o | output | 32 | Current LR contents |

## Verification
The hardest case to reach is a single cycle in which one instruction both jumps through LR and links. That cycle has to show the old LR on next_pc_o, and the value pc + 4 must then appear on lr_o only after the edge. The stimulus first loads LR through a linking displacement branch. It then issues the linking LR jump and samples next_pc_o before the edge and lr_o after it. An external LR write is presented in the same cycle as a linking branch, so the priority rule is exercised. A glue-style sequence of link, then jump through CTR without linking, then return, checks that the caller's return address survives.

// File: rtl/bta_pkg.sv
package bta_pkg;
  localparam int unsigned INSTR_W = 32;

  localparam logic [5:0] OP_REL_U  = 6'd18;
  localparam logic [5:0] OP_REL_C  = 6'd16;
  localparam logic [5:0] OP_INDIR  = 6'd19;
  localparam logic [9:0] XO_TO_LR  = 10'd16;
  localparam logic [9:0] XO_TO_CTR = 10'd528;

  typedef enum logic [2:0] {
    BR_NONE,
    BR_REL_U,
    BR_REL_C,
    BR_TO_LR,
    BR_TO_CTR
  } br_kind_e;
endpackage

// File: rtl/bta_decode.sv
module bta_decode
  import bta_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [INSTR_W-1:0] instr_i,
  output br_kind_e           kind_o,
  output logic [ADDR_W-1:0]  disp_o,
  output logic               abs_o,
  output logic               link_o
);
  // big-endian field positions: bit k lives at instr_i[31-k]
  localparam int unsigned LONG_W  = 24;
  localparam int unsigned SHORT_W = 14;

  logic [5:0]         opcode;
  logic [9:0]         xo;
  logic [LONG_W-1:0]  disp_long;
  logic [SHORT_W-1:0] disp_short;

  assign opcode     = instr_i[31:26];
  assign xo         = instr_i[10:1];
  assign disp_long  = instr_i[25:2];
  assign disp_short = instr_i[15:2];
  assign abs_o      = instr_i[1];
  assign link_o     = instr_i[0];

  always_comb begin
    kind_o = BR_NONE;
    unique case (opcode)
      OP_REL_U: kind_o = BR_REL_U;
      OP_REL_C: kind_o = BR_REL_C;
      OP_INDIR: begin
        if (xo == XO_TO_LR)       kind_o = BR_TO_LR;
        else if (xo == XO_TO_CTR) kind_o = BR_TO_CTR;
      end
      default: kind_o = BR_NONE;
    endcase
  end

  always_comb begin
    if (kind_o == BR_REL_U)
      disp_o = {{(ADDR_W-LONG_W-2){disp_long[LONG_W-1]}}, disp_long, 2'b00};
    else
      disp_o = {{(ADDR_W-SHORT_W-2){disp_short[SHORT_W-1]}}, disp_short, 2'b00};
  end
endmodule

// File: rtl/bta_target.sv
module bta_target
  import bta_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              valid_i,
  input  br_kind_e          kind_i,
  input  logic [ADDR_W-1:0] disp_i,
  input  logic              abs_i,
  input  logic              cond_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] lr_i,
  input  logic [ADDR_W-1:0] ctr_i,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              taken_o
);
  localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

  logic [ADDR_W-1:0] raw_tgt;
  logic [ADDR_W-1:0] seq_pc;

  assign seq_pc = pc_i + STEP;

  always_comb begin
    taken_o = 1'b0;
    raw_tgt = seq_pc;
    if (valid_i) begin
      unique case (kind_i)
        BR_REL_U: begin
          taken_o = 1'b1;
          raw_tgt = abs_i ? disp_i : pc_i + disp_i;
        end
        BR_REL_C: begin
          taken_o = cond_i;
          raw_tgt = abs_i ? disp_i : pc_i + disp_i;
        end
        BR_TO_LR: begin
          taken_o = cond_i;
          raw_tgt = lr_i;
        end
        BR_TO_CTR: begin
          taken_o = cond_i;
          raw_tgt = ctr_i;
        end
        default: taken_o = 1'b0;
      endcase
    end
  end

  assign next_pc_o = taken_o ? (raw_tgt & ALIGN_MASK) : seq_pc;

  always_comb begin
    if (taken_o) AST_TAKEN_NEEDS_VALID: assert (valid_i && kind_i != BR_NONE); // R10
  end
endmodule

// File: rtl/bta_regs.sv
module bta_regs #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_we_i,
  input  logic [ADDR_W-1:0] link_val_i,
  input  logic              lr_we_i,
  input  logic [ADDR_W-1:0] lr_wdata_i,
  input  logic              ctr_we_i,
  input  logic [ADDR_W-1:0] ctr_wdata_i,
  output logic [ADDR_W-1:0] lr_o,
  output logic [ADDR_W-1:0] ctr_o
);
  logic [ADDR_W-1:0] lr_q, ctr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lr_q <= '0;
    else if (link_we_i) lr_q <= link_val_i;  // linking branch wins
    else if (lr_we_i)   lr_q <= lr_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctr_q <= '0;
    else if (ctr_we_i) ctr_q <= ctr_wdata_i;
  end

  assign lr_o  = lr_q;
  assign ctr_o = ctr_q;

  AST_LINK_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_i |=> lr_q == $past(link_val_i)); // R5
  AST_LR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_we_i && !lr_we_i) |=> $stable(lr_q)); // R8
  AST_EXT_LR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lr_we_i && !link_we_i) |=> lr_q == $past(lr_wdata_i)); // R9
  AST_EXT_CTR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctr_we_i |=> ctr_q == $past(ctr_wdata_i)); // R9
endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit
  import bta_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       instr_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              cond_taken_i,
  input  logic              lr_we_i,
  input  logic [ADDR_W-1:0] lr_wdata_i,
  input  logic              ctr_we_i,
  input  logic [ADDR_W-1:0] ctr_wdata_i,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] lr_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  br_kind_e          kind;
  logic [ADDR_W-1:0] disp, lr_q, ctr_q, link_val;
  logic              abs_bit, link_bit, link_we;

  bta_decode #(.ADDR_W(ADDR_W)) u_decode (
    .instr_i (instr_i),
    .kind_o  (kind),
    .disp_o  (disp),
    .abs_o   (abs_bit),
    .link_o  (link_bit)
  );

  bta_target #(.ADDR_W(ADDR_W)) u_target (
    .valid_i   (valid_i),
    .kind_i    (kind),
    .disp_i    (disp),
    .abs_i     (abs_bit),
    .cond_i    (cond_taken_i),
    .pc_i      (pc_i),
    .lr_i      (lr_q),
    .ctr_i     (ctr_q),
    .next_pc_o (next_pc_o),
    .taken_o   (redirect_o)
  );

  // link regardless of outcome; target above already used the old LR
  assign link_we  = valid_i && (kind != BR_NONE) && link_bit;
  assign link_val = pc_i + STEP;

  bta_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .link_we_i   (link_we),
    .link_val_i  (link_val),
    .lr_we_i     (lr_we_i),
    .lr_wdata_i  (lr_wdata_i),
    .ctr_we_i    (ctr_we_i),
    .ctr_wdata_i (ctr_wdata_i),
    .lr_o        (lr_q),
    .ctr_o       (ctr_q)
  );

  assign lr_o = lr_q;

  AST_TARGET_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> next_pc_o[1:0] == 2'b00); // R11
  AST_FALLTHROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redirect_o |-> next_pc_o == pc_i + STEP); // R6
  AST_NO_BRANCH_NO_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !redirect_o); // R10
endmodule

// File: tb/branch_target_unit_tb.sv
`timescale 1ns/1ps
module branch_target_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] pc_i = '0;
  logic        cond_taken_i = 1'b0;
  logic        lr_we_i = 1'b0;
  logic [31:0] lr_wdata_i = '0;
  logic        ctr_we_i = 1'b0;
  logic [31:0] ctr_wdata_i = '0;
  logic [31:0] next_pc_o, lr_o;
  logic        redirect_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;

  branch_target_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .pc_i(pc_i), .cond_taken_i(cond_taken_i), .lr_we_i(lr_we_i),
    .lr_wdata_i(lr_wdata_i), .ctr_we_i(ctr_we_i), .ctr_wdata_i(ctr_wdata_i),
    .next_pc_o(next_pc_o), .redirect_o(redirect_o), .lr_o(lr_o)
  );

  function automatic logic [31:0] mk_b(logic [23:0] d, logic aa, logic lk);
    return {6'd18, d, aa, lk};
  endfunction
  function automatic logic [31:0] mk_bc(logic [13:0] d, logic aa, logic lk);
    return {6'd16, 10'd0, d, aa, lk};
  endfunction
  function automatic logic [31:0] mk_ind(logic [9:0] xo, logic lk);
    return {6'd19, 15'd0, xo, lk};
  endfunction

  // table run with LR = 0x1003, CTR = 0x2002, no vector links
  localparam int NV = 15;
  localparam logic [31:0] V_PC [NV] = '{
    32'h100, 32'h100, 32'h100, 32'h100, 32'h400, 32'h400, 32'h400,
    32'h400, 32'h400, 32'h500, 32'h600, 32'h100, 32'h400, 32'h102, 32'h610};
  localparam logic [31:0] V_INSTR [NV] = '{
    mk_b(24'd4, 1'b0, 1'b0),        mk_b(24'hFFFFFE, 1'b0, 1'b0),
    mk_b(24'h80, 1'b1, 1'b0),       mk_b(24'h800000, 1'b1, 1'b0),
    mk_bc(14'd3, 1'b0, 1'b0),       mk_bc(14'h3FFF, 1'b0, 1'b0),
    mk_bc(14'd3, 1'b0, 1'b0),       mk_ind(10'd16, 1'b0),
    mk_ind(10'd528, 1'b0),          mk_ind(10'd528, 1'b0),
    32'h7C00_0000,                  mk_b(24'd4, 1'b0, 1'b0),
    mk_bc(14'h10, 1'b1, 1'b0),      mk_b(24'd1, 1'b0, 1'b0),
    mk_ind(10'd100, 1'b0)};
  localparam logic V_COND [NV] = '{
    1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [31:0] V_EXP_PC [NV] = '{
    32'h110, 32'hF8, 32'h200, 32'hFE00_0000, 32'h40C, 32'h3FC, 32'h404,
    32'h1000, 32'h2000, 32'h504, 32'h604, 32'h110, 32'h40, 32'h104, 32'h614};
  localparam logic V_EXP_RD [NV] = '{
    1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam string V_TAG [NV] = '{
    "R2", "R2", "R4", "R4", "R3", "R3", "R6", "R7", "R8", "R6", "R10", "R2", "R4", "R11", "R10"};

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [31:0] ins, logic [31:0] pc, logic c);
    @(negedge clk_i);
    valid_i = v; instr_i = ins; pc_i = pc; cond_taken_i = c;
    lr_we_i = 1'b0; ctr_we_i = 1'b0;
    #1;
  endtask

  task automatic idle();
    @(negedge clk_i);
    valid_i = 1'b0; lr_we_i = 1'b0; ctr_we_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state observed after release
    rst_ni = 1'b1;
    #1;
    check("R1 lr after reset", lr_o, 32'h0);
    drive(1'b1, mk_ind(10'd16, 1'b0), 32'h80, 1'b1);
    check("R1 lr jump target", next_pc_o, 32'h0);
    drive(1'b1, mk_ind(10'd528, 1'b0), 32'h80, 1'b1);
    check("R1 ctr jump target", next_pc_o, 32'h0);

    // R9: external writes land at the edge only
    @(negedge clk_i);
    valid_i = 1'b0; lr_we_i = 1'b1; lr_wdata_i = 32'h1003;
    ctr_we_i = 1'b1; ctr_wdata_i = 32'h2002;
    #1;
    check("R9 lr before edge", lr_o, 32'h0);
    idle();
    #1;
    check("R9 lr after edge", lr_o, 32'h1003);

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, V_INSTR[i], V_PC[i], V_COND[i]);
      check({V_TAG[i], " next_pc"}, next_pc_o, V_EXP_PC[i]);
      check({V_TAG[i], " redirect"}, 32'(redirect_o), 32'(V_EXP_RD[i]));
    end
    idle();
    #1;
    check("R8 lr kept over table", lr_o, 32'h1003);

    // R5: linking taken branch
    drive(1'b1, mk_b(24'd4, 1'b0, 1'b1), 32'h300, 1'b1);
    idle();
    #1;
    check("R5 link taken", lr_o, 32'h304);

    // R5/R6: not-taken conditional still links
    drive(1'b1, mk_bc(14'd8, 1'b0, 1'b1), 32'h700, 1'b0);
    check("R6 not taken pc", next_pc_o, 32'h704);
    check("R6 not taken redirect", 32'(redirect_o), 32'h0);
    idle();
    #1;
    check("R5 link not taken", lr_o, 32'h704);

    // R7: jump through LR while linking uses the old LR
    drive(1'b1, mk_ind(10'd16, 1'b1), 32'h800, 1'b1);
    check("R7 old lr target", next_pc_o, 32'h704);
    idle();
    #1;
    check("R7 lr updated", lr_o, 32'h804);

    // R8: glue stub jumps via CTR without touching LR, then return
    drive(1'b1, mk_ind(10'd528, 1'b0), 32'h900, 1'b1);
    check("R8 ctr target", next_pc_o, 32'h2000);
    idle();
    #1;
    check("R8 lr preserved", lr_o, 32'h804);
    drive(1'b1, mk_ind(10'd16, 1'b0), 32'h2000, 1'b1);
    check("R7 return target", next_pc_o, 32'h804);

    // R9: coincident external write loses to linking branch
    @(negedge clk_i);
    valid_i = 1'b1; instr_i = mk_b(24'd2, 1'b0, 1'b1); pc_i = 32'hA00;
    cond_taken_i = 1'b0; lr_we_i = 1'b1; lr_wdata_i = 32'hAAAA_0000; ctr_we_i = 1'b0;
    idle();
    #1;
    check("R9 link priority", lr_o, 32'hA04);

    // R10: invalid linking branch has no effect
    drive(1'b0, mk_b(24'd4, 1'b0, 1'b1), 32'hB00, 1'b1);
    check("R10 invalid pc", next_pc_o, 32'hB04);
    check("R10 invalid redirect", 32'(redirect_o), 32'h0);
    idle();
    #1;
    check("R10 lr untouched", lr_o, 32'hA04);

    // R11: misaligned register contents are aligned
    @(negedge clk_i);
    valid_i = 1'b0; ctr_we_i = 1'b1; ctr_wdata_i = 32'h0000_3007;
    drive(1'b1, mk_ind(10'd528, 1'b0), 32'hC00, 1'b1);
    check("R11 ctr aligned", next_pc_o, 32'h3004);
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule